// File: doc/BRIEF.md
# Manchester Command Frame Detector

This block sits at the end of a digital receive chain. It takes the half-bit stream that a tone demodulator produces, one half-bit per strobe, and turns each pair of half-bits into one data bit. It watches the decoded bits for a start pattern. Once it sees that pattern, it gathers a fixed number of data bits into a command word and compares the word against a small table of valid commands that can be loaded at run time. When the word matches an entry, the block raises a one-cycle detect flag and reports the index of the entry. Every frame has to begin with its own start pattern. A malformed Manchester symbol abandons the frame in progress.

The sequencer has three states. `ST_HUNT` shifts decoded bits into a window and leaves for `ST_COLLECT` when the window equals the start pattern. `ST_COLLECT` gathers the word. It moves on to `ST_COMPARE` after the last bit and falls back to `ST_HUNT` on an invalid symbol. `ST_COMPARE` lasts one cycle: it registers the outcome of the table match and then always returns to `ST_HUNT`, with the search window emptied.

Top module: `cmd_frame_detector`

## Requirements
- R1: While reset is asserted and after it is released, `cmd_hit` is 0, `cmd_idx` is 0, the block is searching for the start pattern, and every table entry is invalid. A frame whose word is all zeros therefore produces no detection until an entry has been written.
- R2: Half-bits pair up in arrival order. The pair (1 then 0) decodes to data bit 1, and the pair (0 then 1) decodes to data bit 0.
- R3: A pair of equal half-bits is an invalid symbol. The second half-bit of that pair becomes the first half of the next pair, so a stream that starts one half-bit out of step comes back into step.
- R4: An invalid symbol while a command word is being gathered abandons the frame without any detection, and the block returns to start-pattern search.
- R5: The start pattern (`start_pat`, oldest bit in the MSB) is found at any bit alignment. A match needs SYNC_W decoded bits received since the last reset, invalid symbol or frame end.
- R6: The FRAME_W decoded bits that follow the start pattern form the command word, with the first bit in the MSB. Bits inside the word that look like the start pattern are still data.
- R7: When the word equals a valid table entry, `cmd_hit` is 1 for exactly one cycle and `cmd_idx` shows that entry. Both appear two clock edges after the edge that samples the final half-bit.
- R8: When no valid entry matches, `cmd_hit` stays 0 and `cmd_idx` keeps its previous value.
- R9: When several valid entries hold the same word, the lowest index is reported.
- R10: After each frame ends, whether or not it matched, the next frame is accepted only after a fresh start pattern. Data bits that follow without one produce no detection.
- R11: A table write with `tbl_valid` = 0 removes that entry from matching. A write with `tbl_valid` = 1 stores `tbl_word` at `tbl_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| half_vld | input | 1 | Strobe: one received half-bit this cycle |
| half_bit | input | 1 | Value of the received half-bit |
| start_pat | input | SYNC_W | Frame start pattern, oldest bit in the MSB |
| tbl_we | input | 1 | Command table write enable |
| tbl_idx | input | IDX_W | Table entry to write |
| tbl_word | input | FRAME_W | Command word to store |
| tbl_valid | input | 1 | Valid flag written with the entry |
| cmd_hit | output | 1 | One-cycle pulse when a command is detected |
| cmd_idx | output | IDX_W | Index of the last detected command |

## Verification
A pairing phase that drifts shows up as a wrong or missing detection on the next frame. It also stops the stream from coming back into step after a deliberate stray half-bit. A hunt window that is not emptied at frame end shows up as an extra pulse when data follows a frame with no start pattern. A frame counter that is off by one moves the word by a bit, so the table match fails and no pulse appears. The reference model predicts `cmd_hit` and `cmd_idx` for every cycle, so any of these faults is reported at the first cycle where a pulse is expected or appears early.

// File: rtl/cfd_pkg.sv
package cfd_pkg;

    typedef enum logic [1:0] {
        ST_HUNT    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_COMPARE = 2'd2
    } seq_state_e;

endpackage

// File: rtl/cfd_manchester.sv
// Pairs incoming half-bits into Manchester symbols.
// (1,0) -> 1, (0,1) -> 0, equal halves -> error with a slip of one half-bit.
module cfd_manchester (
    input  logic clk,
    input  logic rst_n,
    input  logic half_vld,
    input  logic half_bit,
    output logic dec_vld,
    output logic dec_bit,
    output logic dec_err
);

    logic have_first;
    logic first_half;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_first <= 1'b0;
            first_half <= 1'b0;
            dec_vld    <= 1'b0;
            dec_bit    <= 1'b0;
            dec_err    <= 1'b0;
        end else begin
            dec_vld <= 1'b0;
            dec_err <= 1'b0;
            if (half_vld) begin
                if (!have_first) begin
                    first_half <= half_bit;
                    have_first <= 1'b1;
                end else if (first_half != half_bit) begin
                    dec_vld    <= 1'b1;
                    dec_bit    <= first_half;
                    have_first <= 1'b0;
                end else begin
                    // invalid symbol: keep the second half as the start of a new pair
                    dec_err    <= 1'b1;
                    first_half <= half_bit;
                    have_first <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/cfd_cmd_table.sv
// Loadable table of command words; compares one probe word against all entries.
module cfd_cmd_table #(
    parameter int FRAME_W = 16,
    parameter int N_CMD   = 16,
    parameter int IDX_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [FRAME_W-1:0] wr_word,
    input  logic               wr_valid,
    input  logic [FRAME_W-1:0] probe_word,
    output logic               hit_any,
    output logic [IDX_W-1:0]   hit_idx
);

    logic [FRAME_W-1:0] entry_word [N_CMD];
    logic [N_CMD-1:0]   entry_ok;
    logic [N_CMD-1:0]   match_vec;

    for (genvar g = 0; g < N_CMD; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                entry_word[g] <= '0;
                entry_ok[g]   <= 1'b0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                entry_word[g] <= wr_word;
                entry_ok[g]   <= wr_valid;
            end
        end

        assign match_vec[g] = entry_ok[g] && (entry_word[g] == probe_word);
    end

    // lowest index wins
    always_comb begin
        hit_idx = '0;
        for (int i = N_CMD - 1; i >= 0; i--) begin
            if (match_vec[i]) begin
                hit_idx = IDX_W'(i);
            end
        end
    end

    assign hit_any = |match_vec;

endmodule

// File: rtl/cfd_sequencer.sv
// Frame sequencer: start-pattern hunt, word collection, registered compare.
module cfd_sequencer
    import cfd_pkg::*;
#(
    parameter int SYNC_W  = 8,
    parameter int FRAME_W = 16,
    parameter int IDX_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               dec_vld,
    input  logic               dec_bit,
    input  logic               dec_err,
    input  logic [SYNC_W-1:0]  start_pat,
    input  logic               match_any,
    input  logic [IDX_W-1:0]   match_idx,
    output logic [FRAME_W-1:0] frame_word,
    output logic               cmd_hit,
    output logic [IDX_W-1:0]   cmd_idx,
    output seq_state_e         state
);

    localparam int FILL_W = $clog2(SYNC_W + 1);
    localparam int CNT_W  = (FRAME_W > 1) ? $clog2(FRAME_W) : 1;

    seq_state_e        state_n;
    logic [SYNC_W-1:0] hunt_sh;
    logic [SYNC_W-1:0] hunt_next;
    logic [FILL_W-1:0] hunt_fill;
    logic [CNT_W-1:0]  bit_cnt;
    logic              sync_seen;
    logic              last_bit;

    assign hunt_next = {hunt_sh[SYNC_W-2:0], dec_bit};
    assign sync_seen = dec_vld
                    && (hunt_fill >= FILL_W'(SYNC_W - 1))
                    && (hunt_next == start_pat);
    assign last_bit  = dec_vld && (bit_cnt == CNT_W'(FRAME_W - 1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_HUNT;
        end else begin
            state <= state_n;
        end
    end

    // next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            ST_HUNT: begin
                if (sync_seen) begin
                    state_n = ST_COLLECT;
                end
            end
            ST_COLLECT: begin
                if (dec_err) begin
                    state_n = ST_HUNT;
                end else if (last_bit) begin
                    state_n = ST_COMPARE;
                end
            end
            ST_COMPARE: begin
                state_n = ST_HUNT;
            end
            default: begin
                state_n = ST_HUNT;
            end
        endcase
    end

    // hunt window and word collection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hunt_sh    <= '0;
            hunt_fill  <= '0;
            bit_cnt    <= '0;
            frame_word <= '0;
        end else begin
            unique case (state)
                ST_HUNT: begin
                    bit_cnt <= '0;
                    if (dec_err || sync_seen) begin
                        hunt_fill <= '0;
                        hunt_sh   <= '0;
                    end else if (dec_vld) begin
                        hunt_sh <= hunt_next;
                        if (hunt_fill < FILL_W'(SYNC_W)) begin
                            hunt_fill <= hunt_fill + 1'b1;
                        end
                    end
                end
                ST_COLLECT: begin
                    hunt_fill <= '0;
                    hunt_sh   <= '0;
                    if (dec_vld && !dec_err) begin
                        frame_word <= {frame_word[FRAME_W-2:0], dec_bit};
                        bit_cnt    <= bit_cnt + 1'b1;
                    end
                end
                ST_COMPARE: begin
                    hunt_fill <= '0;
                    hunt_sh   <= '0;
                    bit_cnt   <= '0;
                end
                default: begin
                    hunt_fill <= '0;
                end
            endcase
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_hit <= 1'b0;
            cmd_idx <= '0;
        end else begin
            cmd_hit <= 1'b0;
            if ((state == ST_COMPARE) && match_any) begin
                cmd_hit <= 1'b1;
                cmd_idx <= match_idx;
            end
        end
    end

endmodule

// File: rtl/cmd_frame_detector.sv
// Top: Manchester decode, start-pattern framing, command table match.
module cmd_frame_detector
    import cfd_pkg::*;
#(
    parameter  int SYNC_W  = 8,
    parameter  int FRAME_W = 16,
    parameter  int N_CMD   = 16,
    localparam int IDX_W   = (N_CMD > 1) ? $clog2(N_CMD) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               half_vld,
    input  logic               half_bit,
    input  logic [SYNC_W-1:0]  start_pat,
    input  logic               tbl_we,
    input  logic [IDX_W-1:0]   tbl_idx,
    input  logic [FRAME_W-1:0] tbl_word,
    input  logic               tbl_valid,
    output logic               cmd_hit,
    output logic [IDX_W-1:0]   cmd_idx
);

    logic               dec_vld;
    logic               dec_bit;
    logic               dec_err;
    logic [FRAME_W-1:0] frame_word;
    logic               match_any;
    logic [IDX_W-1:0]   match_idx;
    seq_state_e         seq_state;

    cfd_manchester u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .half_vld (half_vld),
        .half_bit (half_bit),
        .dec_vld  (dec_vld),
        .dec_bit  (dec_bit),
        .dec_err  (dec_err)
    );

    cfd_cmd_table #(
        .FRAME_W (FRAME_W),
        .N_CMD   (N_CMD),
        .IDX_W   (IDX_W)
    ) u_tbl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (tbl_we),
        .wr_idx     (tbl_idx),
        .wr_word    (tbl_word),
        .wr_valid   (tbl_valid),
        .probe_word (frame_word),
        .hit_any    (match_any),
        .hit_idx    (match_idx)
    );

    cfd_sequencer #(
        .SYNC_W  (SYNC_W),
        .FRAME_W (FRAME_W),
        .IDX_W   (IDX_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .dec_vld    (dec_vld),
        .dec_bit    (dec_bit),
        .dec_err    (dec_err),
        .start_pat  (start_pat),
        .match_any  (match_any),
        .match_idx  (match_idx),
        .frame_word (frame_word),
        .cmd_hit    (cmd_hit),
        .cmd_idx    (cmd_idx),
        .state      (seq_state)
    );

endmodule

// File: rtl/cfd_checker.sv
module cfd_checker
    import cfd_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             dec_vld,
    input logic             dec_err,
    input seq_state_e       seq_state,
    input logic             cmd_hit,
    input logic [IDX_W-1:0] cmd_idx
);

    // R2: a decoded bit needs two half-bits, so never two in a row
    p_pair_rate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dec_vld |=> !dec_vld);

    // R3: a symbol is either a bit or an error, never both
    p_symbol_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(dec_vld && dec_err));

    // R4: invalid symbol while collecting drops back to hunt
    p_abort_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == ST_COLLECT && dec_err) |=> (seq_state == ST_HUNT));

    // R5: collection is entered only from hunt
    p_collect_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == ST_COLLECT && $past(seq_state) != ST_COLLECT)
            |-> ($past(seq_state) == ST_HUNT));

    // R7: detect pulse lasts one cycle
    p_hit_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_hit |=> !cmd_hit);

    // R7: detect pulse only follows a compare cycle
    p_hit_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_hit |-> ($past(seq_state) == ST_COMPARE));

    // R8: index only changes together with a detect pulse
    p_idx_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_hit |-> $stable(cmd_idx));

    // R10: every frame end returns to hunt
    p_resync_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == ST_COMPARE) |=> (seq_state == ST_HUNT));

endmodule

bind cmd_frame_detector cfd_checker #(.IDX_W(IDX_W)) u_cfd_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dec_vld   (dec_vld),
    .dec_err   (dec_err),
    .seq_state (seq_state),
    .cmd_hit   (cmd_hit),
    .cmd_idx   (cmd_idx)
);

// File: tb/cmd_frame_detector_bench.sv
module cmd_frame_detector_bench;

    localparam int CLK_PERIOD = 10;
    localparam int SW = 8;
    localparam int FW = 16;
    localparam int NC = 16;
    localparam int IW = 4;
    localparam int WATCHDOG = 50000;
    localparam logic [SW-1:0] SYNC = 8'hE5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          half_vld = 1'b0;
    logic          half_bit = 1'b0;
    logic          tbl_we = 1'b0;
    logic [IW-1:0] tbl_idx = '0;
    logic [FW-1:0] tbl_word = '0;
    logic          tbl_valid = 1'b0;
    logic          cmd_hit;
    logic [IW-1:0] cmd_idx;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cmd_frame_detector #(
        .SYNC_W  (SW),
        .FRAME_W (FW),
        .N_CMD   (NC)
    ) u_cmd_frame_detector (
        .clk       (clk),
        .rst_n     (rst_n),
        .half_vld  (half_vld),
        .half_bit  (half_bit),
        .start_pat (SYNC),
        .tbl_we    (tbl_we),
        .tbl_idx   (tbl_idx),
        .tbl_word  (tbl_word),
        .tbl_valid (tbl_valid),
        .cmd_hit   (cmd_hit),
        .cmd_idx   (cmd_idx)
    );

    int    n_checks = 0;
    int    n_fail = 0;
    int    hit_seen = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    // ---------------- behavioural reference model ----------------
    bit            m_have;
    bit            m_first;
    bit            m_q[$];
    bit            m_collect;
    int            m_cnt;
    logic [FW-1:0] m_word;
    logic [FW-1:0] m_tbl [NC];
    bit            m_tv [NC];
    bit            s1_hit, s2_hit, e_hit;
    int            s1_idx, s2_idx, e_idx;
    bit            nh;
    int            ni;

    task automatic model_bit(input bit b);
        logic [SW-1:0] v;
        if (!m_collect) begin
            m_q.push_back(b);
            if (m_q.size() > SW) void'(m_q.pop_front());
            if (m_q.size() == SW) begin
                v = '0;
                foreach (m_q[i]) v = {v[SW-2:0], m_q[i]};
                if (v == SYNC) begin
                    m_collect = 1'b1;
                    m_cnt = 0;
                    m_q.delete();
                end
            end
        end else begin
            m_word = {m_word[FW-2:0], b};
            m_cnt++;
            if (m_cnt == FW) begin
                for (int i = NC - 1; i >= 0; i--) begin
                    if (m_tv[i] && m_tbl[i] == m_word) begin
                        nh = 1'b1;
                        ni = i;
                    end
                end
                m_collect = 1'b0;
                m_q.delete();
            end
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_have = 0; m_first = 0; m_q.delete(); m_collect = 0; m_cnt = 0;
            m_word = '0;
            for (int i = 0; i < NC; i++) begin m_tbl[i] = '0; m_tv[i] = 0; end
            s1_hit = 0; s2_hit = 0; e_hit = 0; s1_idx = 0; s2_idx = 0; e_idx = 0;
        end else begin
            nh = 0; ni = 0;
            if (half_vld) begin
                if (!m_have) begin
                    m_first = half_bit; m_have = 1;
                end else if (m_first != half_bit) begin
                    m_have = 0;
                    model_bit(m_first);
                end else begin
                    m_first = half_bit; m_have = 1;
                    m_collect = 0; m_q.delete();
                end
            end
            if (tbl_we) begin
                m_tbl[tbl_idx] = tbl_word;
                m_tv[tbl_idx]  = tbl_valid;
            end
            e_hit = s2_hit;
            if (s2_hit) e_idx = s2_idx;
            s2_hit = s1_hit; s2_idx = s1_idx;
            s1_hit = nh;     s1_idx = ni;
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_checks++;
            if (cmd_hit !== e_hit || cmd_idx !== IW'(e_idx)) begin
                n_fail++;
                $display("FAIL %s cycle model: hit=%0b idx=%0d expected hit=%0b idx=%0d",
                         cur_req, cmd_hit, cmd_idx, e_hit, e_idx);
            end
            if (cmd_hit === 1'b1) hit_seen++;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk) half_vld = 1'b0;
    endtask

    task automatic send_half(input bit b, input bit fast);
        @(negedge clk);
        half_vld = 1'b1;
        half_bit = b;
        if (!fast) begin
            @(negedge clk);
            half_vld = 1'b0;
        end
    endtask

    task automatic send_bit(input bit b, input bit fast);
        send_half(b, fast);
        send_half(!b, fast);
    endtask

    task automatic send_bits(input logic [FW-1:0] w, input int n, input bit fast);
        for (int i = n - 1; i >= 0; i--) send_bit(w[i], fast);
    endtask

    task automatic send_frame(input logic [FW-1:0] w, input bit fast);
        send_bits(FW'(SYNC), SW, fast);
        send_bits(w, FW, fast);
        idle(1);
    endtask

    task automatic write_entry(input int idx, input logic [FW-1:0] w, input bit v);
        @(negedge clk);
        tbl_we = 1'b1; tbl_idx = IW'(idx); tbl_word = w; tbl_valid = v;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic expect_hits(input string req, input int n_exp, input int idx_exp);
        idle(5);
        check(hit_seen == n_exp, req, "detect pulses", hit_seen, n_exp);
        check(cmd_idx == IW'(idx_exp), req, "command index", int'(cmd_idx), idx_exp);
        hit_seen = 0;
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    // ---------------- test sequence ----------------
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cur_req = "R1";
        check(cmd_hit == 1'b0, "R1", "hit after reset", int'(cmd_hit), 0);
        check(cmd_idx == '0, "R1", "index after reset", int'(cmd_idx), 0);

        // empty table: all-zero word must not match an unwritten entry
        cur_req = "R1";
        hit_seen = 0;
        send_frame(16'h0000, 1'b0);
        expect_hits("R1", 0, 0);

        write_entry(3, 16'h1234, 1'b1);
        write_entry(5, 16'hBEEF, 1'b1);
        write_entry(9, 16'hBEEF, 1'b1);
        write_entry(7, 16'hE5E5, 1'b1);

        // R2 / R7: plain frame decodes and matches entry 3
        cur_req = "R7";
        send_frame(16'h1234, 1'b0);
        expect_hits("R2 R7", 1, 3);

        // R9: duplicate word in entries 5 and 9 reports 5
        cur_req = "R9";
        send_frame(16'hBEEF, 1'b0);
        expect_hits("R9", 1, 5);

        // R8: unknown word, index holds at 5
        cur_req = "R8";
        send_frame(16'h5555, 1'b0);
        expect_hits("R8", 0, 5);

        // R5: stray bits before the start pattern
        cur_req = "R5";
        send_bit(1'b1, 1'b0); send_bit(1'b0, 1'b0); send_bit(1'b1, 1'b0);
        send_frame(16'h1234, 1'b0);
        expect_hits("R5", 1, 3);

        // R3: one stray half-bit, stream realigns through slip
        cur_req = "R3";
        send_half(1'b1, 1'b0);
        send_frame(16'h1234, 1'b0);
        expect_hits("R3", 1, 3);

        // R4: invalid symbol in the middle of the word
        cur_req = "R4";
        send_bits(FW'(SYNC), SW, 1'b0);
        send_bits(16'h0012, 8, 1'b0);
        send_half(1'b1, 1'b0); send_half(1'b1, 1'b0); send_half(1'b0, 1'b0);
        send_bits(16'h0034, 8, 1'b0);
        expect_hits("R4", 0, 3);
        send_frame(16'hBEEF, 1'b0);
        expect_hits("R4", 1, 5);

        // R10: word repeated with no new start pattern
        cur_req = "R10";
        send_frame(16'h1234, 1'b0);
        send_bits(16'h1234, FW, 1'b0);
        expect_hits("R10", 1, 3);

        // R6: word that contains the start pattern, strobes back to back
        cur_req = "R6";
        send_frame(16'hE5E5, 1'b1);
        expect_hits("R6", 1, 7);

        // R11: clearing entry 5 leaves entry 9 as the match
        cur_req = "R11";
        write_entry(5, 16'hBEEF, 1'b0);
        send_frame(16'hBEEF, 1'b1);
        expect_hits("R11", 1, 9);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule